// File: doc/BRIEF.md
# DMA Channel Interrupt Controller

This block collects the event pulses of a single DMA channel into a 12-bit sticky status word. It qualifies that word with a mask and drives one level interrupt line. Software reaches it through a small 32-bit word-addressed register port. The mask is never written directly. An enable port clears mask bits and a disable port sets them, so two agents can change different sources without a read-modify-write race. Status bits are cleared by writing ones to them.

Two 8-bit accounting counters, one per side, count descriptor completions for the source and destination sides. Reading a counter returns its value and clears it. When a counter wraps past 255, a dedicated error status bit is set for that side. An access to an address that decodes to nothing, or to an address that is not word aligned, sets its own status bit.

Register map (byte offsets, 32-bit data, bit 0 is the least significant bit): 0x00 status (read; write-one-to-clear), 0x04 mask (read only), 0x08 enable port (write only; reads return 0), 0x0C disable port (write only; reads return 0), 0x10 source counter (read-to-clear), 0x14 destination counter (read-to-clear).

Top module: `dmairq_ctrl`

## Requirements
- R1: After a synchronous reset the status is 0x000, the mask is 0xFFF, both counters are 0 and irq_o is low.
- R2: A pulse on evt_i bit 3 or on bits 6 to 11 sets the same status bit. The bit meanings are: 3 byte-count overflow, 6 source descriptor read error, 7 destination descriptor read error, 8 data read error, 9 data write error, 10 transfer done, 11 pause.
- R3: irq_o is high exactly when some status bit is 1 and its mask bit is 0. It follows the edge on which status or mask changes.
- R4: A write to 0x08 clears every mask bit whose wdata bit is 1, and a write to 0x0C sets them. Writes to 0x04 and to the counter addresses change nothing.
- R5: Writing 1 to a bit of 0x00 clears that status bit. Bits written 0 keep their value.
- R6: If an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R7: A pulse on evt_i bit 1 (source descriptor done) sets status bit 1 and adds one to the source counter. Bit 2 does the same for the destination side and its counter.
- R8: An increment that takes a counter from 255 to 0 also sets status bit 4 (source side) or bit 5 (destination side).
- R9: A read of a counter returns its value and leaves it 0. If an increment arrives in the same cycle, the counter leaves that cycle at 1.
- R10: A read or write to an address that is above 0x14 or not a multiple of 4 sets status bit 0, changes no other register, and reads back 0.
- R11: Pulses on evt_i bits 0, 4 and 5 have no effect.
- R12: rdata_o is registered. It holds the addressed value on the cycle after the read, with bits 31 to 12 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Register access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| evt_i | input | NEVT | Single-cycle event pulses from the channel |
| irq_o | output | 1 | Level interrupt, registered |

## Verification
A stuck or wrongly merged status bit shows up at irq_o on the very next edge once that source is unmasked, and it shows up in a status read one cycle after the access. A counter that is off by one can stay hidden until it is read or until it wraps. The bench therefore reads counters after short runs and also drives a full 256-event wrap, where a wrong count moves the error bit by at least one pulse. Decode faults show up as a changed bit 0 or as a register that was wrongly touched, checked by reading back every neighbour.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int NUM_EVT = 12;
  localparam int BIT_BADACC  = 0;
  localparam int BIT_SRCDONE = 1;
  localparam int BIT_DSTDONE = 2;
  localparam int BIT_SRCWRAP = 4;
  localparam int BIT_DSTWRAP = 5;
  // word index of each register
  localparam logic [2:0] W_STATUS = 3'd0;
  localparam logic [2:0] W_MASK   = 3'd1;
  localparam logic [2:0] W_ENABLE = 3'd2;
  localparam logic [2:0] W_DISABL = 3'd3;
  localparam logic [2:0] W_SRCCNT = 3'd4;
  localparam logic [2:0] W_DSTCNT = 3'd5;
  localparam int NUM_WORDS = 6;
endpackage

// File: rtl/dmairq_acct.sv
module dmairq_acct #(
  parameter int ACC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             rd_clr,
  output logic [ACC_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [ACC_W-1:0] ONE = ACC_W'(1);

  assign wrap = inc && !rd_clr && (cnt == '1);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (rd_clr)
      cnt <= inc ? ONE : '0;
    else if (inc)
      cnt <= cnt + ONE;
  end
endmodule

// File: rtl/dmairq_status.sv
module dmairq_status #(
  parameter int NEVT = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NEVT-1:0] set_vec,
  input  logic [NEVT-1:0] w1c_vec,
  input  logic [NEVT-1:0] mclr_vec,
  input  logic [NEVT-1:0] mset_vec,
  output logic [NEVT-1:0] status,
  output logic [NEVT-1:0] mask,
  output logic            irq
);
  logic [NEVT-1:0] st_d;
  logic [NEVT-1:0] mk_d;

  always_comb begin
    st_d = (status & ~w1c_vec) | set_vec;
    mk_d = (mask & ~mclr_vec) | mset_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      mask   <= '1;
      irq    <= 1'b0;
    end else begin
      status <= st_d;
      mask   <= mk_d;
      irq    <= |(st_d & ~mk_d);
    end
  end
endmodule

// File: rtl/dmairq_ctrl.sv
module dmairq_ctrl
  import dmairq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NEVT   = NUM_EVT,
  parameter int ACC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NEVT-1:0]   evt_i,
  output logic              irq_o
);
  localparam int NSIDE = 2;
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic              aligned, known, bad_acc;
  logic              wr, rd;
  logic [NEVT-1:0]   set_vec, w1c_vec, mclr_vec, mset_vec;
  logic [NEVT-1:0]   status_q, mask_q;
  logic [NSIDE-1:0]  acct_inc, acct_clr, acct_wrap;
  logic [NSIDE-1:0][ACC_W-1:0] acct_cnt;
  logic              unused_hi;

  assign unused_hi = ^wdata_i[DATA_W-1:NEVT];

  assign widx    = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign known   = aligned && (widx < WIDX_W'(NUM_WORDS));
  assign bad_acc = req_i && !known;
  assign wr      = req_i && we_i && known;
  assign rd      = req_i && !we_i && known;

  assign w1c_vec  = (wr && widx == WIDX_W'(W_STATUS)) ? wdata_i[NEVT-1:0] : '0;
  assign mclr_vec = (wr && widx == WIDX_W'(W_ENABLE)) ? wdata_i[NEVT-1:0] : '0;
  assign mset_vec = (wr && widx == WIDX_W'(W_DISABL)) ? wdata_i[NEVT-1:0] : '0;

  assign acct_inc[0] = evt_i[BIT_SRCDONE];
  assign acct_inc[1] = evt_i[BIT_DSTDONE];
  assign acct_clr[0] = rd && widx == WIDX_W'(W_SRCCNT);
  assign acct_clr[1] = rd && widx == WIDX_W'(W_DSTCNT);

  generate
    for (genvar s = 0; s < NSIDE; s++) begin : g_side
      dmairq_acct #(.ACC_W(ACC_W)) u_acct (
        .clk    (clk),
        .rst    (rst),
        .inc    (acct_inc[s]),
        .rd_clr (acct_clr[s]),
        .cnt    (acct_cnt[s]),
        .wrap   (acct_wrap[s])
      );
    end
  endgenerate

  always_comb begin
    set_vec = evt_i;
    set_vec[BIT_BADACC]  = bad_acc;
    set_vec[BIT_SRCWRAP] = acct_wrap[0];
    set_vec[BIT_DSTWRAP] = acct_wrap[1];
  end

  dmairq_status #(.NEVT(NEVT)) u_status (
    .clk      (clk),
    .rst      (rst),
    .set_vec  (set_vec),
    .w1c_vec  (w1c_vec),
    .mclr_vec (mclr_vec),
    .mset_vec (mset_vec),
    .status   (status_q),
    .mask     (mask_q),
    .irq      (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (req_i && !we_i) begin
      rdata_o <= '0;
      if (known) begin
        case (widx)
          WIDX_W'(W_STATUS): rdata_o[NEVT-1:0]  <= status_q;
          WIDX_W'(W_MASK):   rdata_o[NEVT-1:0]  <= mask_q;
          WIDX_W'(W_SRCCNT): rdata_o[ACC_W-1:0] <= acct_cnt[0];
          WIDX_W'(W_DSTCNT): rdata_o[ACC_W-1:0] <= acct_cnt[1];
          default:           rdata_o <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/dmairq_ctrl_chk.sv
module dmairq_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NEVT   = 12,
  parameter int ACC_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [NEVT-1:0]   evt_i,
  input logic              irq_o,
  input logic [NEVT-1:0]   status,
  input logic [NEVT-1:0]   mask,
  input logic [ACC_W-1:0]  src_cnt,
  input logic              src_inc,
  input logic              src_clr
);
  localparam logic [NEVT-1:0] EXT_BITS = NEVT'(12'hFC8);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_DIS = ADDR_W'(12);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (status == '0 && mask == '1 && !irq_o && src_cnt == '0)); // R1

  AST_EVT_STICKS: assert property (@(posedge clk) disable iff (rst)
    (|(evt_i & EXT_BITS)) |=> ((status & $past(evt_i & EXT_BITS)) == $past(evt_i & EXT_BITS))); // R6

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|(status & ~mask))); // R3

  AST_EN_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (req_i && we_i && addr_i == A_EN) |=> ((mask & $past(wdata_i[NEVT-1:0])) == '0)); // R4

  AST_DIS_SETS: assert property (@(posedge clk) disable iff (rst)
    (req_i && we_i && addr_i == A_DIS) |=>
      ((mask & $past(wdata_i[NEVT-1:0])) == $past(wdata_i[NEVT-1:0]))); // R4

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
    (src_inc && !src_clr && src_cnt == '1) |=> (status[4] && src_cnt == '0)); // R8
endmodule

bind dmairq_ctrl dmairq_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NEVT(NEVT), .ACC_W(ACC_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .evt_i   (evt_i),
  .irq_o   (irq_o),
  .status  (status_q),
  .mask    (mask_q),
  .src_cnt (acct_cnt[0]),
  .src_inc (acct_inc[0]),
  .src_clr (acct_clr[0])
);

// File: tb/dmairq_ctrl_tb.sv
module dmairq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_ST = 8'h00, A_MK = 8'h04, A_EN = 8'h08,
                         A_DI = 8'h0C, A_SC = 8'h10, A_DC = 8'h14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [11:0] evt_i = '0;
  logic        irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmairq_ctrl u_dut (
    .clk(clk), .rst(rst), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .evt_i(evt_i), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [7:0] a, input logic [31:0] d,
                     input logic [11:0] ev, output logic [31:0] rd);
    @(negedge clk);
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d; evt_i = ev;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0; evt_i = '0;
    rd = rdata_o;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] x;
    acc(1'b1, a, d, '0, x);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    acc(1'b0, a, '0, '0, v);
  endtask

  task automatic pulse(input logic [11:0] ev);
    @(negedge clk);
    evt_i = ev;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq", {31'd0, irq_o}, 32'd0);
    rd(A_ST, v); check("R1 status", v, 32'h0);
    rd(A_MK, v); check("R1 mask", v, 32'hFFF);
    rd(A_SC, v); check("R1 src cnt", v, 32'h0);
    rd(A_DC, v); check("R1 dst cnt", v, 32'h0);
  endtask

  task automatic t_events();
    logic [31:0] v;
    pulse(12'hFC8);
    check("R3 masked irq low", {31'd0, irq_o}, 32'd0);
    rd(A_ST, v); check("R2 external bits", v, 32'hFC8);
    check("R12 upper bits zero", v & 32'hFFFF_F000, 32'h0);
    wr(A_ST, 32'hFFF);
    rd(A_ST, v); check("R5 all cleared", v, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    pulse(12'h400);
    wr(A_EN, 32'h400);
    check("R3 irq after enable", {31'd0, irq_o}, 32'd1);
    rd(A_MK, v); check("R4 enable clears", v, 32'hBFF);
    wr(A_MK, 32'h0);
    rd(A_MK, v); check("R4 mask write ignored", v, 32'hBFF);
    wr(A_DI, 32'h400);
    check("R3 irq after disable", {31'd0, irq_o}, 32'd0);
    rd(A_MK, v); check("R4 disable sets", v, 32'hFFF);
    wr(A_EN, 32'h600);
    check("R3 irq re-enabled", {31'd0, irq_o}, 32'd1);
    wr(A_ST, 32'h200);
    rd(A_ST, v); check("R5 zero bits kept", v, 32'h400);
    check("R3 irq still high", {31'd0, irq_o}, 32'd1);
    wr(A_ST, 32'h400);
    check("R3 irq drops on clear", {31'd0, irq_o}, 32'd0);
    wr(A_DI, 32'hFFF);
  endtask

  task automatic t_collide();
    logic [31:0] v, x;
    pulse(12'h800);
    acc(1'b1, A_ST, 32'h800, 12'h800, x);
    rd(A_ST, v); check("R6 event wins", v, 32'h800);
    wr(A_ST, 32'hFFF);
  endtask

  task automatic t_counters();
    logic [31:0] v, x;
    for (int i = 0; i < 3; i++) pulse(12'h002);
    pulse(12'h006);
    rd(A_SC, v); check("R7 src count", v, 32'd4);
    rd(A_SC, v); check("R9 src read-cleared", v, 32'd0);
    rd(A_DC, v); check("R7 dst count", v, 32'd1);
    rd(A_ST, v); check("R7 done bits", v, 32'h006);
    pulse(12'h002); pulse(12'h002);
    acc(1'b0, A_SC, '0, 12'h002, x); check("R9 read returns old", x, 32'd2);
    rd(A_SC, v); check("R9 coincident inc", v, 32'd1);
    wr(A_SC, 32'h55);
    rd(A_DC, v); check("R4 counter write ignored", v, 32'd0);
    wr(A_ST, 32'hFFF);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    for (int i = 0; i < 255; i++) pulse(12'h004);
    rd(A_ST, v); check("R8 no wrap at 255", v & 32'h020, 32'h0);
    pulse(12'h004);
    rd(A_ST, v); check("R8 dst wrap flag", v, 32'h024);
    rd(A_DC, v); check("R8 dst wrapped to 0", v, 32'd0);
    wr(A_ST, 32'hFFF);
    for (int i = 0; i < 256; i++) pulse(12'h002);
    rd(A_ST, v); check("R8 src wrap flag", v, 32'h012);
    rd(A_SC, v); check("R8 src wrapped to 0", v, 32'd0);
    wr(A_ST, 32'hFFF);
  endtask

  task automatic t_bad();
    logic [31:0] v;
    pulse(12'h100);
    rd(8'h18, v); check("R10 undecoded reads 0", v, 32'h0);
    rd(A_ST, v); check("R10 bit0 on bad read", v, 32'h101);
    wr(8'h02, 32'hFFF);
    rd(A_ST, v); check("R10 unaligned write no clear", v, 32'h101);
    wr(8'h09, 32'hFFF);
    rd(A_MK, v); check("R10 unaligned no unmask", v, 32'hFFF);
    wr(A_ST, 32'hFFF);
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    wr(A_EN, 32'h031);
    pulse(12'h031);
    check("R11 irq stays low", {31'd0, irq_o}, 32'd0);
    rd(A_ST, v); check("R11 status unchanged", v, 32'h0);
    rd(A_SC, v); check("R11 src cnt unchanged", v, 32'h0);
    rd(A_DC, v); check("R11 dst cnt unchanged", v, 32'h0);
    wr(A_DI, 32'hFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_events();
    t_mask();
    t_collide();
    t_counters();
    t_wrap();
    t_bad();
    t_ignored();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule